// File: doc/BRIEF.md
# Four-Channel Tick-Rate Timer Bank

The block is a timer peripheral on a simple 32-bit word-addressed register bus. It holds four identical count channels. Each channel advances on its own tick enable, and that enable is divided down from the single system clock. Channel 0 ticks at 32768 Hz, channel 1 at 1 kHz, and channels 2 and 3 at 1 MHz. The system clock frequency is a parameter, and each channel's divider is derived from it at elaboration.

A channel counts up from zero on every tick while it runs. When a tick arrives with the count equal to the programmed limit, the channel raises its pending flag and the count returns to zero. In repeating mode the channel keeps running after that. In single-shot mode it stops itself. Each channel drives one level-sensitive interrupt line, gated by its own interrupt-enable bit.

One shared clock-request register sits above the four channel windows. While its enable bit is clear, no tick enables reach any channel.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero and all interrupt lines are low.
- R2: The bus address port carries bits 8..2 of the byte offset. Channel n occupies the window at byte offset n*0x40. Inside a window the registers are:
  - 0x00 control (read/write): bit0 run, bit1 single-shot, bit2 interrupt enable.
  - 0x04 limit (read/write, 32 bits).
  - 0x08 count (read-only).
  - 0x0C status (read-only): bit0 pending, bit1 running.
  - 0x10 acknowledge (write-only).
- R3: The clock-request register is at byte offset 0x100. Only its bit0 is stored, and all other bits read as zero.
- R4: Reads of unmapped offsets, write-only offsets and read-only registers' write side return zero. Writes to unmapped offsets and to read-only registers change nothing.
- R5: While clock-request bit0 is clear, no channel ticks and every count holds. Each divider restarts from zero, so a channel's first tick lands D cycles after the clock request is set.
- R6: The divider D for a channel is round(CLK_HZ / rate), with a minimum of 1. The rates are 32768 Hz, 1000 Hz, 1 MHz and 1 MHz for channels 0 to 3.
- R7: On each tick of a running channel the count increments. A tick that finds count equal to limit instead sets pending and clears count, so the period is limit+1 ticks. In repeating mode the channel keeps running.
- R8: In single-shot mode the expiring tick also clears the run bit. The channel then stays stopped with count zero.
- R9: On a write to the acknowledge register:
  - bit0 clears pending;
  - bit1 clears count;
  - an expiry in the same cycle keeps pending set.
- R10: Interrupt n is high exactly while channel n has pending set and its interrupt-enable bit set. It follows a change of the enable bit with no tick needed.
- R11: Channels are independent. Programming or ticking one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address, byte-offset bits 8..2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe, zero otherwise |
| irq | output | 4 | Level interrupt per channel |

## Verification
The bound checker watches every cycle for the following:
- counts that move while the clock request is off;
- a pending flag that rises without a tick to cause it;
- a single-shot run bit that drops without expiry;
- an interrupt line high without pending;
- non-zero data on unmapped reads and on the clock-request register's upper bits.

Only the bench scenarios can show the arithmetic of the dividers. They also show the exact tick counts inside a timed enable window, the restart of a divider after the request is dropped, the limit+1 period, acknowledge semantics and isolation between windows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH   = 4;                 // channel count
    localparam int DW    = 32;                // register width
    localparam int AW    = 9;                 // byte offset width
    localparam int CH_W  = $clog2(NCH);       // channel select width
    localparam int WIN_W = 4;                 // word-index width inside a window (0x40 bytes)

    localparam logic [WIN_W-1:0] REG_CTRL   = 4'd0;
    localparam logic [WIN_W-1:0] REG_LIMIT  = 4'd1;
    localparam logic [WIN_W-1:0] REG_COUNT  = 4'd2;
    localparam logic [WIN_W-1:0] REG_STATUS = 4'd3;
    localparam logic [WIN_W-1:0] REG_ACK    = 4'd4;

    // clock-request register sits just beyond the last channel window
    localparam int CLKREQ_WORD = NCH << WIN_W;

    typedef struct packed {
        logic ien;      // bit2
        logic single;   // bit1
        logic run;      // bit0
    } ctrl_t;

    function automatic int unsigned rate_of(input int idx);
        case (idx)
            0:       return 32'd32768;
            1:       return 32'd1000;
            default: return 32'd1000000;
        endcase
    endfunction

    function automatic int unsigned tick_div(input longint unsigned clk_hz,
                                             input longint unsigned rate_hz);
        longint unsigned q;
        q = (clk_hz + rate_hz / 2) / rate_hz;
        return (q == 0) ? 32'd1 : 32'(q);
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tg_state_t;

    tg_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = en && (s_q.cnt == LAST);
        if (!en) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_ctrl,
    input  logic          wr_limit,
    input  logic          wr_ack,
    input  logic [DW-1:0] wdata,
    output logic [2:0]    ctrl,
    output logic [DW-1:0] limit,
    output logic [DW-1:0] count,
    output logic          pending,
    output logic          irq
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] limit;
        logic [DW-1:0] count;
        logic          pend;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      step;
    logic      expire;

    always_comb begin
        step   = s_q.ctrl.run && tick;
        expire = step && (s_q.count == s_q.limit);
        s_d    = s_q;

        // counting: terminal match wraps and flags
        if (step) begin
            if (expire) begin
                s_d.count = '0;
                s_d.pend  = 1'b1;
                if (s_q.ctrl.single) begin
                    s_d.ctrl.run = 1'b0;
                end
            end else begin
                s_d.count = s_q.count + DW'(1);
            end
        end

        // bus writes override the counting result, except pending on expiry
        if (wr_limit) begin
            s_d.limit = wdata;
        end
        if (wr_ctrl) begin
            s_d.ctrl = ctrl_t'(wdata[2:0]);
        end
        if (wr_ack) begin
            if (wdata[1]) begin
                s_d.count = '0;
            end
            if (wdata[0] && !expire) begin
                s_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl    = s_q.ctrl;
    assign limit   = s_q.limit;
    assign count   = s_q.count;
    assign pending = s_q.pend;
    assign irq     = s_q.pend & s_q.ctrl.ien;

endmodule

// File: rtl/tmr_regmux.sv
module tmr_regmux
    import tmr_pkg::*;
(
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [AW-1:2]            bus_addr,
    input  logic [NCH-1:0][2:0]      ch_ctrl,
    input  logic [NCH-1:0][DW-1:0]   ch_limit,
    input  logic [NCH-1:0][DW-1:0]   ch_count,
    input  logic [NCH-1:0]           ch_pend,
    input  logic                     clk_req,
    output logic [NCH-1:0]           wr_ctrl,
    output logic [NCH-1:0]           wr_limit,
    output logic [NCH-1:0]           wr_ack,
    output logic                     wr_clkreq,
    output logic [DW-1:0]            rdata
);
    logic             in_chan;
    logic             is_clkreq;
    logic [CH_W-1:0]  sel;
    logic [WIN_W-1:0] ix;
    logic             do_wr;
    logic             do_rd;

    always_comb begin
        in_chan   = !bus_addr[AW-1];
        is_clkreq = (bus_addr == (AW-2)'(CLKREQ_WORD));
        sel       = bus_addr[WIN_W+CH_W+1:WIN_W+2];
        ix        = bus_addr[WIN_W+1:2];
        do_wr     = bus_valid && bus_write;
        do_rd     = bus_valid && !bus_write;

        for (int i = 0; i < NCH; i++) begin
            wr_ctrl[i]  = do_wr && in_chan && (sel == CH_W'(i)) && (ix == REG_CTRL);
            wr_limit[i] = do_wr && in_chan && (sel == CH_W'(i)) && (ix == REG_LIMIT);
            wr_ack[i]   = do_wr && in_chan && (sel == CH_W'(i)) && (ix == REG_ACK);
        end
        wr_clkreq = do_wr && is_clkreq;

        rdata = '0;
        if (do_rd) begin
            if (in_chan) begin
                case (ix)
                    REG_CTRL:   rdata = {{(DW-3){1'b0}}, ch_ctrl[sel]};
                    REG_LIMIT:  rdata = ch_limit[sel];
                    REG_COUNT:  rdata = ch_count[sel];
                    REG_STATUS: rdata = {{(DW-2){1'b0}}, ch_ctrl[sel][0], ch_pend[sel]};
                    default:    rdata = '0;
                endcase
            end else if (is_clkreq) begin
                rdata = {{(DW-1){1'b0}}, clk_req};
            end
        end
    end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [AW-1:2]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NCH-1:0]  irq
);
    typedef struct packed {
        logic clk_req;
    } top_state_t;

    top_state_t s_d, s_q;

    logic                   clk_req_q;
    logic                   wr_clkreq;
    logic [NCH-1:0]         tick;
    logic [NCH-1:0]         wr_ctrl;
    logic [NCH-1:0]         wr_limit;
    logic [NCH-1:0]         wr_ack;
    logic [NCH-1:0][2:0]    ch_ctrl;
    logic [NCH-1:0][DW-1:0] ch_limit;
    logic [NCH-1:0][DW-1:0] ch_cnt;
    logic [NCH-1:0]         ch_pend;
    logic [NCH-1:0]         ch_run;

    always_comb begin
        s_d = s_q;
        if (wr_clkreq) begin
            s_d.clk_req = bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_req_q = s_q.clk_req;

    tmr_regmux u_mux (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .ch_ctrl   (ch_ctrl),
        .ch_limit  (ch_limit),
        .ch_count  (ch_cnt),
        .ch_pend   (ch_pend),
        .clk_req   (clk_req_q),
        .wr_ctrl   (wr_ctrl),
        .wr_limit  (wr_limit),
        .wr_ack    (wr_ack),
        .wr_clkreq (wr_clkreq),
        .rdata     (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_tick_gen #(
            .DIV (tick_div(CLK_HZ, rate_of(i)))
        ) u_tick (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (clk_req_q),
            .tick  (tick[i])
        );

        tmr_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[i]),
            .wr_ctrl  (wr_ctrl[i]),
            .wr_limit (wr_limit[i]),
            .wr_ack   (wr_ack[i]),
            .wdata    (bus_wdata),
            .ctrl     (ch_ctrl[i]),
            .limit    (ch_limit[i]),
            .count    (ch_cnt[i]),
            .pending  (ch_pend[i]),
            .irq      (irq[i])
        );

        assign ch_run[i] = ch_ctrl[i][0];
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [AW-1:2]          bus_addr,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0]         irq,
    input logic                   clk_req,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         pend,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0][DW-1:0] cnt
);
    localparam logic [AW-3:0] CR_W = (AW-2)'(CLKREQ_WORD);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5
        count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clk_req && !bus_valid) |=> $stable(cnt[i]));

        // R7
        pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(tick[i] && run[i]));

        // R8
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(run[i]) && !$past(bus_valid && bus_write)) |-> (pend[i] && $past(tick[i])));

        // R10
        irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> pend[i]);
    end

    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write &&
         ((bus_addr[AW-1] && bus_addr != CR_W) || (!bus_addr[AW-1] && bus_addr[WIN_W+1:2] > 4'd3)))
        |-> (bus_rdata == '0));

    // R3
    clkreq_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == CR_W) |-> (bus_rdata[DW-1:1] == '0));

endmodule

bind tmr_bank tmr_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .clk_req   (clk_req_q),
    .tick      (tick),
    .pend      (ch_pend),
    .run       (ch_run),
    .cnt       (ch_cnt)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;

    localparam int unsigned BENCH_HZ = 4_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [8:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    tmr_bank #(.CLK_HZ(BENCH_HZ)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // R6: divider per channel, round-to-nearest
    function automatic int bdiv(input int rate);
        return (BENCH_HZ + rate / 2) / rate;
    endfunction

    // R2: word address of register r in channel ch
    function automatic logic [8:2] wa(input int ch, input int r);
        return 7'(ch * 16 + r);
    endfunction

    localparam logic [8:2] CR = 7'h40;

    task automatic bwr(input logic [8:2] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic brd(input logic [8:2] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a;
        exp_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic irq_is(input logic [3:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back('{is_irq: 1'b1, exp: {28'd0, e}, tag: tag});
    endtask

    // clock request held on for exactly n cycles
    task automatic run_window(input int n);
        bwr(CR, 32'd1);
        repeat (n - 1) @(posedge clk);
        bwr(CR, 32'd0);
    endtask

    // monitor: compares queued expectations away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.is_irq ? {28'd0, irq} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        brd(CR,        32'd0, "R1 clkreq");
        brd(wa(0, 0),  32'd0, "R1 ch0 ctrl");
        brd(wa(1, 1),  32'd0, "R1 ch1 limit");
        brd(wa(2, 2),  32'd0, "R1 ch2 count");
        brd(wa(3, 3),  32'd0, "R1 ch3 status");
        irq_is(4'h0,          "R1 irq");

        // R4 unmapped and read-only accesses
        bwr(7'h41,     32'hFFFF_FFFF);
        bwr(wa(0, 5),  32'h1234_5678);
        bwr(wa(2, 2),  32'h55);
        brd(wa(2, 2),  32'd0, "R4 count not writable");
        brd(CR,        32'd0, "R4 clkreq untouched");
        brd(7'h41,     32'd0, "R4 unmapped 0x104");
        brd(wa(0, 5),  32'd0, "R4 unmapped ch0 0x14");
        brd(wa(0, 4),  32'd0, "R4 ack reads zero");

        // R2 / R11 window separation
        bwr(wa(3, 1),  32'hDEAD_BEEF);
        brd(wa(3, 1),  32'hDEAD_BEEF, "R2 ch3 limit readback");
        brd(wa(2, 1),  32'd0,         "R11 ch2 limit untouched");
        bwr(wa(3, 1),  32'd0);

        // R5 no ticks while clock request clear
        bwr(wa(2, 1),  32'd3);
        bwr(wa(2, 0),  32'h5);
        repeat (40) @(posedge clk);
        brd(wa(2, 2),  32'd0, "R5 count holds");
        brd(wa(2, 3),  32'h2, "R5 status running");
        brd(wa(2, 0),  32'h5, "R2 ctrl readback");

        // R7 repeating count (ch2 divider 4)
        run_window(3 * bdiv(1000000) + 2);
        brd(wa(2, 2),  32'd3, "R7 three ticks");
        irq_is(4'h0,          "R7 no irq before limit");
        run_window(bdiv(1000000));
        brd(wa(2, 2),  32'd0, "R7 wrap at limit");
        brd(wa(2, 3),  32'h3, "R7 pending and running");
        irq_is(4'h4,          "R10 ch2 irq");
        run_window(2 * bdiv(1000000));
        brd(wa(2, 2),  32'd2, "R7 keeps counting");

        // R9 acknowledge
        bwr(wa(2, 4),  32'h1);
        brd(wa(2, 3),  32'h2, "R9 pending cleared");
        irq_is(4'h0,          "R9 irq dropped");
        brd(wa(2, 2),  32'd2, "R9 count kept by bit0");
        bwr(wa(2, 4),  32'h2);
        brd(wa(2, 2),  32'd0, "R9 count cleared by bit1");
        bwr(wa(2, 0),  32'h0);

        // R10 enable gating (ch3, limit 0)
        bwr(wa(3, 0),  32'h1);
        run_window(bdiv(1000000));
        brd(wa(3, 3),  32'h3, "R10 ch3 pending");
        irq_is(4'h0,          "R10 masked");
        bwr(wa(3, 0),  32'h5);
        irq_is(4'h8,          "R10 enable raises irq");
        bwr(wa(3, 0),  32'h1);
        irq_is(4'h0,          "R10 disable lowers irq");
        bwr(wa(3, 0),  32'h0);
        bwr(wa(3, 4),  32'h1);

        // R8 single-shot (ch2, limit 2)
        bwr(wa(2, 1),  32'd2);
        bwr(wa(2, 0),  32'h7);
        run_window(10 * bdiv(1000000));
        brd(wa(2, 0),  32'h6, "R8 run cleared");
        brd(wa(2, 2),  32'd0, "R8 count zero");
        brd(wa(2, 3),  32'h1, "R8 pending only");
        irq_is(4'h4,          "R8 irq");
        run_window(2 * bdiv(1000000));
        brd(wa(2, 2),  32'd0, "R8 stays stopped");
        bwr(wa(2, 4),  32'h1);
        irq_is(4'h0,          "R9 ack after one-shot");

        // R6 / R5 divider lengths and restart
        bwr(wa(0, 1),  32'd1000);
        bwr(wa(0, 0),  32'h1);
        run_window(250);
        brd(wa(0, 2),  32'(250 / bdiv(32768)), "R6 ch0 divider");
        run_window(bdiv(32768) - 1);
        brd(wa(0, 2),  32'(250 / bdiv(32768)), "R5 divider restarts");
        run_window(bdiv(32768));
        brd(wa(0, 2),  32'(250 / bdiv(32768) + 1), "R5 first tick after D");
        bwr(wa(1, 1),  32'd1000);
        bwr(wa(1, 0),  32'h1);
        run_window(bdiv(1000) - 1);
        brd(wa(1, 2),  32'd0, "R6 ch1 short window");
        run_window(bdiv(1000));
        brd(wa(1, 2),  32'd1, "R6 ch1 divider");
        brd(wa(0, 2),  32'(250 / bdiv(32768) + 1 + 2 * ((bdiv(1000) - 1) / bdiv(32768))
                           + (bdiv(1000) / bdiv(32768)) - ((bdiv(1000) - 1) / bdiv(32768))),
            "R11 ch0 independent of ch1");
        bwr(wa(0, 0),  32'h0);
        bwr(wa(1, 0),  32'h0);

        // R3 only bit0 stored
        bwr(CR,        32'hFFFF_FFFF);
        brd(CR,        32'd1, "R3 clkreq bit0 only");
        bwr(CR,        32'd0);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule